// File: doc/BRIEF.md
# Sequenced Bus Trace Capture Unit

This block listens passively to a 32-bit multiplexed address/data bus and its three active-low handshake lines. It records only the bus words that match a programmed, masked pattern during a completed data phase. Each stored word carries a cycle timestamp that counts from the moment an external start trigger was accepted. A small trace memory can therefore cover a long stretch of bus activity, and the spacing between events can be read back afterwards.

A three-level sequencer sets when capture happens. In the state **WAIT_TRIG** (level 1) the block waits for the start trigger and stores nothing. The transition *trigger accepted* moves it to **WAIT_FIRST** (level 2), where the first matching word is stored. The transition *first hit* moves it to **COLLECT** (level 3), where every further match is stored. The transition *memory filled* leads from WAIT_FIRST or COLLECT to **FULL**, which freezes the trace. Two more transitions exist. The *alternate jump* is optional and moves WAIT_FIRST or COLLECT to a programmed level when the trigger input rises again. The *arm command* returns any state to WAIT_TRIG and empties the trace.

Software configures the block through a small write port. Once the block is idle or full, it drains the entries in capture order through a read port.

Top module: `bus_trace_seq`

## Requirements
- R1: After reset the block is in level 1 with entry count 0 and the full flag low. The pattern register holds 32'h2D976000 and the mask register holds all ones.
- R2: In level 1 no word is stored, whatever the bus carries. A cycle with `start_trig` high moves the sequencer to level 2, unless an arm command arrives in the same cycle.
- R3: A bus cycle qualifies only when `bus_frame_n`=1, `bus_devsel_n`=0 and `bus_trdy_n`=0. A word seen in any other combination of these three lines is never stored.
- R4: A word matches when `((bus_ad ^ pattern) & mask) == 0`. Configuration writes set the registers by address: 0 = pattern, 1 = mask, 2 = mode, 3 = command.
- R5: In level 2 the first qualified match is stored at entry 0 (or at the current count), and the sequencer moves to level 3.
- R6: In level 3 every qualified match is stored at the next entry in capture order, and the count rises by one per stored word.
- R7: When the count reaches DEPTH, the full flag is set and the level reads 3. No further word is stored until an arm command arrives.
- R8: Leaving level 1 clears a TS_W-bit cycle counter. A word captured on the N-th rising edge after the edge that accepted the trigger carries stamp N-1. The stamp saturates at 2^TS_W-1 and does not wrap.
- R9: Mode bit 0 enables the alternate jump, and mode bits [2:1] select its target (2 = level 2, 3 = level 3, any other value = level 1). With the jump enabled, `start_trig` high in level 2 or 3 on a cycle without a match moves the sequencer to the target level. Stored entries are kept. A match in the same cycle takes priority over the jump.
- R10: Writing 1 to bit 0 of the command register returns the sequencer to level 1 and resets the count to 0. The command has priority over every other transition.
- R11: A cycle with `rd_en` high returns `rd_word` and `rd_stamp` for entry `rd_addr` one cycle later, with `rd_valid` high. This happens only when the sequencer was in level 1 or full at the request. Otherwise `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ad | input | 32 | Monitored address/data lines |
| bus_frame_n | input | 1 | Frame handshake line |
| bus_devsel_n | input | 1 | Device-select handshake line |
| bus_trdy_n | input | 1 | Target-ready handshake line |
| start_trig | input | 1 | External start trigger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| rd_en | input | 1 | Trace read request |
| rd_addr | input | ADDR_W | Entry index to read |
| rd_valid | output | 1 | Read data valid |
| rd_word | output | 32 | Captured bus word |
| rd_stamp | output | TS_W | Captured timestamp |
| stat_level | output | 2 | Current sequencer level (1..3) |
| stat_count | output | CNT_W | Number of stored entries |
| stat_full | output | 1 | Trace memory full |

## Verification
Some properties can be checked on every cycle, and the assertions do so. The count never moves by more than one step. Nothing is stored while the sequencer sits in level 1 or while the bus cycle does not qualify. A full trace stays full with its count at DEPTH. An arm command always lands in level 1 with zero entries. Reads refused outside level 1 and FULL never produce a valid strobe. Other behaviours only show up in the bench's scenarios: which words the mask lets through, the exact timestamp values including saturation, the capture order seen on readback, and where the alternate jump lands.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_TRIG  = 2'd0,
        ST_WAIT_FIRST = 2'd1,
        ST_COLLECT    = 2'd2,
        ST_FULL       = 2'd3
    } tsc_state_e;

    localparam logic [1:0] CFG_PATTERN = 2'd0;
    localparam logic [1:0] CFG_MASK    = 2'd1;
    localparam logic [1:0] CFG_MODE    = 2'd2;
    localparam logic [1:0] CFG_CMD     = 2'd3;

    function automatic logic [1:0] level_of(tsc_state_e s);
        logic [1:0] lvl;
        unique case (s)
            ST_WAIT_TRIG:  lvl = 2'd1;
            ST_WAIT_FIRST: lvl = 2'd2;
            ST_COLLECT:    lvl = 2'd3;
            ST_FULL:       lvl = 2'd3;
        endcase
        return lvl;
    endfunction

    function automatic tsc_state_e alt_target(logic [1:0] sel);
        tsc_state_e t;
        unique case (sel)
            2'd2:    t = ST_WAIT_FIRST;
            2'd3:    t = ST_COLLECT;
            default: t = ST_WAIT_TRIG;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tsc_match.sv
module tsc_match #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ad,
    input  logic              frame_n,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic [DATA_W-1:0] pattern,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    logic phase_ok;
    logic word_ok;

    always_comb begin
        phase_ok = frame_n && !devsel_n && !trdy_n;
        word_ok  = ((ad ^ pattern) & mask) == '0;
        hit      = phase_ok && word_ok;
    end
endmodule

// File: rtl/tsc_stamp.sv
module tsc_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [TS_W-1:0] stamp
);
    localparam logic [TS_W-1:0] TS_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (clear) begin
            stamp <= '0;
        end else if (stamp != TS_MAX) begin
            stamp <= stamp + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_ram.sv
module tsc_ram #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
    import tsc_pkg::*;
#(
    parameter int DEPTH  = 4096,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             trig,
    input  logic             arm,
    input  logic             alt_en,
    input  logic [1:0]       alt_sel,
    output logic             wr_en,
    output logic [AW-1:0]    wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             stamp_clear,
    output logic             rd_ok,
    output logic [1:0]       level,
    output logic             full
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    tsc_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_TRIG;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (arm) begin
            state_d = ST_WAIT_TRIG;        // arm command
            count_d = '0;
        end else begin
            unique case (state_q)
                ST_WAIT_TRIG: begin
                    if (trig) begin
                        state_d = ST_WAIT_FIRST; // trigger accepted
                    end
                end
                ST_WAIT_FIRST, ST_COLLECT: begin
                    if (hit) begin
                        count_d = count_q + 1'b1;
                        state_d = (count_q == LAST_SLOT) ? ST_FULL : ST_COLLECT;
                    end else if (alt_en && trig) begin
                        state_d = alt_target(alt_sel); // alternate jump
                    end
                end
                ST_FULL: begin
                    state_d = ST_FULL;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en       = !arm && hit &&
                      (state_q == ST_WAIT_FIRST || state_q == ST_COLLECT);
        stamp_clear = !arm && trig && (state_q == ST_WAIT_TRIG);
        rd_ok       = (state_q == ST_WAIT_TRIG) || (state_q == ST_FULL);
        wr_ptr      = count_q[AW-1:0];
        count       = count_q;
        level       = level_of(state_q);
        full        = (state_q == ST_FULL);
    end
endmodule

// File: rtl/bus_trace_seq.sv
module bus_trace_seq
    import tsc_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          TS_W        = 32,
    parameter int          DEPTH       = 4096,
    parameter logic [31:0] PATTERN_RST = 32'h2D976000,
    localparam int         ADDR_W      = $clog2(DEPTH),
    localparam int         CNT_W       = $clog2(DEPTH + 1),
    localparam int         ENTRY_W     = TS_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_ad,
    input  logic              bus_frame_n,
    input  logic              bus_devsel_n,
    input  logic              bus_trdy_n,
    input  logic              start_trig,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    output logic [TS_W-1:0]   rd_stamp,
    output logic [1:0]        stat_level,
    output logic [CNT_W-1:0]  stat_count,
    output logic              stat_full
);
    logic [DATA_W-1:0] pattern_q;
    logic [DATA_W-1:0] mask_q;
    logic              alt_en_q;
    logic [1:0]        alt_sel_q;
    logic              arm;
    logic              hit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_ptr;
    logic              stamp_clear;
    logic [TS_W-1:0]   stamp;
    logic              rd_ok;
    logic              rd_fire;
    logic [ENTRY_W-1:0] rd_entry;

    assign arm     = cfg_we && (cfg_addr == CFG_CMD) && cfg_wdata[0];
    assign rd_fire = rd_en && rd_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= DATA_W'(PATTERN_RST);
            mask_q    <= '1;
            alt_en_q  <= 1'b0;
            alt_sel_q <= 2'd0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_PATTERN: pattern_q <= DATA_W'(cfg_wdata);
                CFG_MASK:    mask_q    <= DATA_W'(cfg_wdata);
                CFG_MODE: begin
                    alt_en_q  <= cfg_wdata[0];
                    alt_sel_q <= cfg_wdata[2:1];
                end
                CFG_CMD: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
        end
    end

    tsc_match #(.DATA_W(DATA_W)) u_match (
        .ad       (bus_ad),
        .frame_n  (bus_frame_n),
        .devsel_n (bus_devsel_n),
        .trdy_n   (bus_trdy_n),
        .pattern  (pattern_q),
        .mask     (mask_q),
        .hit      (hit)
    );

    tsc_seq #(.DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .trig        (start_trig),
        .arm         (arm),
        .alt_en      (alt_en_q),
        .alt_sel     (alt_sel_q),
        .wr_en       (wr_en),
        .wr_ptr      (wr_ptr),
        .count       (stat_count),
        .stamp_clear (stamp_clear),
        .rd_ok       (rd_ok),
        .level       (stat_level),
        .full        (stat_full)
    );

    tsc_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stamp_clear),
        .stamp (stamp)
    );

    tsc_ram #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata ({stamp, bus_ad}),
        .re    (rd_fire),
        .raddr (rd_addr),
        .rdata (rd_entry)
    );

    assign rd_word  = rd_entry[DATA_W-1:0];
    assign rd_stamp = rd_entry[ENTRY_W-1:DATA_W];
endmodule

// File: rtl/bus_trace_seq_chk.sv
module bus_trace_seq_chk #(
    parameter int  DEPTH = 4096,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_frame_n,
    input logic             bus_devsel_n,
    input logic             bus_trdy_n,
    input logic             arm,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [1:0]       stat_level,
    input logic [CNT_W-1:0] stat_count,
    input logic             stat_full
);
    // R7
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_full |-> (stat_count == CNT_W'(DEPTH)));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && !arm) |=> stat_full);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((stat_count == $past(stat_count)) ||
                  (stat_count == $past(stat_count) + CNT_W'(1))));

    // R2
    idle_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_level == 2'd1) |=> (stat_count <= $past(stat_count)));

    // R3
    unqual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !(bus_frame_n && !bus_devsel_n && !bus_trdy_n))
        |=> (stat_count == $past(stat_count)));

    // R10
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ((stat_count == '0) && (stat_level == 2'd1) && !stat_full));

    // R11
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !((stat_level == 2'd1) || stat_full)) |=> !rd_valid);
endmodule

bind bus_trace_seq bus_trace_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_frame_n  (bus_frame_n),
    .bus_devsel_n (bus_devsel_n),
    .bus_trdy_n   (bus_trdy_n),
    .arm          (arm),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .stat_level   (stat_level),
    .stat_count   (stat_count),
    .stat_full    (stat_full)
);

// File: tb/bus_trace_seq_bench.sv
module bus_trace_seq_bench;
    localparam int DEPTH  = 8;
    localparam int TS_W   = 5;
    localparam int AW     = 3;
    localparam int CW     = 4;
    localparam int TS_MAX = 31;
    localparam logic [31:0] DEF_PAT = 32'h2D976000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   bus_ad = '0;
    logic          bus_frame_n = 1'b1;
    logic          bus_devsel_n = 1'b1;
    logic          bus_trdy_n = 1'b1;
    logic          start_trig = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [31:0]   rd_word;
    logic [TS_W-1:0] rd_stamp;
    logic [1:0]    stat_level;
    logic [CW-1:0] stat_count;
    logic          stat_full;

    always #5 clk = ~clk;

    bus_trace_seq #(.TS_W(TS_W), .DEPTH(DEPTH)) u_bus_trace_seq (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_frame_n(bus_frame_n),
        .bus_devsel_n(bus_devsel_n), .bus_trdy_n(bus_trdy_n),
        .start_trig(start_trig), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_stamp(rd_stamp),
        .stat_level(stat_level), .stat_count(stat_count), .stat_full(stat_full)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: level 1,2,3 or 4 = full
    int m_lvl = 1;
    int m_n = 0;
    int m_ts = 0;
    logic [31:0] m_pat = DEF_PAT;
    logic [31:0] m_msk = '1;
    bit m_alt_en = 0;
    int m_alt_lvl = 0;
    logic [31:0] exp_word [DEPTH];
    int exp_stamp [DEPTH];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_status();
        string req;
        int lv;
        req = (m_lvl == 1) ? "R2" : (m_lvl == 2) ? "R5" : (m_lvl == 3) ? "R6" : "R7";
        lv  = (m_lvl == 4) ? 3 : m_lvl;
        check(stat_level == 2'(lv), req, "level", stat_level, lv);
        check(stat_count == CW'(m_n), req, "count", stat_count, m_n);
        check(stat_full == (m_lvl == 4), req, "full", stat_full, (m_lvl == 4));
    endtask

    task automatic step(input logic [31:0] ad, input logic f, input logic d,
                        input logic t, input logic trig, input logic we,
                        input logic [1:0] a, input logic [31:0] wd,
                        input logic re, input logic [AW-1:0] ra);
        bit hit, arm, exitl, rd_exp;
        int old_ts;
        @(negedge clk);
        bus_ad = ad; bus_frame_n = f; bus_devsel_n = d; bus_trdy_n = t;
        start_trig = trig; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        rd_en = re; rd_addr = ra;
        hit    = f && !d && !t && (((ad ^ m_pat) & m_msk) == 32'd0);
        arm    = we && (a == 2'd3) && wd[0];
        rd_exp = re && (m_lvl == 1 || m_lvl == 4);
        old_ts = m_ts;
        exitl  = 0;
        @(posedge clk);
        #1;
        if (arm) begin
            m_lvl = 1; m_n = 0;
        end else if (m_lvl == 1) begin
            if (trig) begin m_lvl = 2; exitl = 1; end
        end else if (m_lvl == 2 || m_lvl == 3) begin
            if (hit) begin
                exp_word[m_n] = ad; exp_stamp[m_n] = old_ts; m_n++;
                m_lvl = (m_n == DEPTH) ? 4 : 3;
            end else if (m_alt_en && trig) begin
                m_lvl = (m_alt_lvl == 2) ? 2 : (m_alt_lvl == 3) ? 3 : 1;
            end
        end
        m_ts = exitl ? 0 : ((m_ts < TS_MAX) ? m_ts + 1 : m_ts);
        if (we && a == 2'd0) m_pat = wd;
        if (we && a == 2'd1) m_msk = wd;
        if (we && a == 2'd2) begin m_alt_en = wd[0]; m_alt_lvl = int'(wd[2:1]); end
        check_status();
        check(rd_valid == rd_exp, "R11", "rd_valid", rd_valid, rd_exp);
        if (rd_exp && rd_valid) begin
            check(rd_word == exp_word[ra], "R11", "word", rd_word, exp_word[ra]);
            check(int'(rd_stamp) == exp_stamp[ra], "R8", "stamp", rd_stamp, exp_stamp[ra]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic bus(input logic [31:0] ad);
        step(ad, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic trig();
        step('0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic cfg(input logic [1:0] a, input logic [31:0] wd);
        step('0, 1, 1, 1, 0, 1, a, wd, 0, 0);
    endtask
    task automatic rd(input int idx);
        step('0, 1, 1, 1, 0, 0, 0, 0, 1, AW'(idx));
    endtask
    task automatic read_all();
        for (int i = 0; i < m_n; i++) rd(i);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(stat_level == 2'd1, "R1", "level", stat_level, 1);
        check(stat_count == '0, "R1", "count", stat_count, 0);
        check(!stat_full, "R1", "full", stat_full, 0);
        check(!rd_valid, "R1", "rd_valid", rd_valid, 0);

        // R2: matches in level 1 are ignored
        repeat (3) bus(DEF_PAT);
        trig();
        idle(3);
        bus(DEF_PAT);          // R5 and R1 default pattern
        bus(32'h1234_5678);
        bus(DEF_PAT);          // R6

        // R3: sweep all handshake combinations with a matching word
        for (int c = 0; c < 8; c++) step(DEF_PAT, c[2], c[1], c[0], 0, 0, 0, 0, 0, 0);
        // R4: single-bit mismatches under a full mask
        for (int b = 0; b < 32; b++) bus(DEF_PAT ^ (32'd1 << b));

        // R4: partial mask
        cfg(2'd1, 32'hFFFF_0000);
        bus(32'h2D97_1234);
        bus(32'h2D98_0000);
        rd(0);                 // R11 blocked in level 3
        for (int i = 0; i < 7; i++) bus(32'h2D97_0000 | 32'(i * 7));   // R7 fill and overflow
        read_all();
        trig();                // alternate disabled: no effect in FULL

        // R10 arm command
        cfg(2'd3, 32'd1);
        rd(1);                 // readable in level 1
        cfg(2'd1, 32'hFFFF_FFFF);

        // R8 stamps and saturation
        trig();
        bus(DEF_PAT);
        bus(DEF_PAT);
        idle(40);
        bus(DEF_PAT);

        // R9 alternate jump to level 1
        cfg(2'd2, 32'b011);
        trig();
        read_all();
        bus(DEF_PAT);          // ignored in level 1
        trig();
        idle(2);
        bus(DEF_PAT);
        // R9 jump to level 2, and match priority over jump
        cfg(2'd2, 32'b101);
        trig();
        step(DEF_PAT, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        cfg(2'd2, 32'b111);
        trig();
        bus(DEF_PAT);
        bus(DEF_PAT);
        bus(DEF_PAT);
        read_all();
        cfg(2'd3, 32'd1);      // R10 from FULL
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule